// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block is pure combinational logic in the decode stage of a five-stage pipeline. It supplies the two source operands of the instruction being decoded. A result that has been computed further down the pipe, but has not yet been written to the register file, is taken directly from the pipeline register that holds it. Operands that have no newer copy in flight come from the register file read ports.

There are five bypass candidates:

- the ALU output currently being produced in execute;
- the data just read from memory in the memory stage;
- the ALU result held in the memory-stage register;
- the load result held in the write-back register;
- the ALU result held in the write-back register.

Each candidate has a destination register ID. A candidate is used only when that ID equals the operand's source ID. The reserved ID of all ones (0xF with the default 4-bit IDs) means "no register" and never matches. When several candidates match, the youngest producer wins.

Operand A has one extra path. For call and jump instructions it carries the incremented PC of the decoded instruction, and this path overrides every register bypass. Hazard stalling is handled elsewhere. A load followed by a dependent instruction is expected to be held back one cycle, so that the loaded value is seen on the memory-stage read-data path. The block has no clock and no handshake: its outputs follow its inputs within the same cycle.

Top module: `fwd_operand_sel`

## Requirements
- R1: When no bypass candidate's destination ID equals an operand's source ID, that operand equals its register-file read data.
- R2: A match with the execute ALU destination selects the execute ALU value, whatever else matches.
- R3: A match with the memory-stage load destination selects the memory read data over the memory-register ALU result and over both write-back values.
- R4: A match with the memory-register ALU destination selects that value over both write-back values.
- R5: A match with the write-back load destination selects the write-back load value over the write-back ALU value.
- R6: A match with the write-back ALU destination alone selects the write-back ALU value over the register file.
- R7: When the use-PC input is 1, operand A equals the incremented PC regardless of any match, and operand B is unaffected.
- R8: The ID with all bits set (0xF) never matches. A source ID of 0xF together with a destination ID of 0xF yields the register-file data.
- R9: Operands A and B are selected independently. The same candidate may feed both, and different candidates may feed each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | RID_W | Source register ID for operand A |
| dec_src_b | input | RID_W | Source register ID for operand B |
| rf_data_a | input | DATA_W | Register-file read data for operand A |
| rf_data_b | input | DATA_W | Register-file read data for operand B |
| dec_pc_next | input | DATA_W | Incremented PC of the decoded instruction |
| dec_use_pc | input | 1 | 1 for call/jump: operand A takes the incremented PC |
| ex_alu_dst | input | RID_W | Destination ID of the ALU result in execute |
| ex_alu_val | input | DATA_W | ALU result being produced in execute |
| mem_load_dst | input | RID_W | Destination ID of the load in the memory stage |
| mem_load_val | input | DATA_W | Data read from memory this cycle |
| mem_alu_dst | input | RID_W | Destination ID of the ALU result in the memory register |
| mem_alu_val | input | DATA_W | ALU result held in the memory register |
| wb_load_dst | input | RID_W | Destination ID of the load result in write-back |
| wb_load_val | input | DATA_W | Load result held in the write-back register |
| wb_alu_dst | input | RID_W | Destination ID of the ALU result in write-back |
| wb_alu_val | input | DATA_W | ALU result held in the write-back register |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
The block holds no state, so any fault in the match or priority logic shows on opnd_a or opnd_b within the same cycle as the input pattern that exposes it. A faulty priority order only becomes visible when two or more candidates name the same register, so every priority pair is driven with back-to-back writers to one register, each carrying a distinct value. A fault in the reserved-ID handling only becomes visible when an idle stage carries ID 0xF and the decoded operand also names 0xF.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Candidate index order is the priority order: index 0 is the youngest producer
  localparam int unsigned NUM_SRC = 5;
  typedef enum logic [2:0] {
    SRC_EX_ALU   = 3'd0,
    SRC_MEM_LOAD = 3'd1,
    SRC_MEM_ALU  = 3'd2,
    SRC_WB_LOAD  = 3'd3,
    SRC_WB_ALU   = 3'd4
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned RID_W = 4,
  parameter int unsigned N     = 5
) (
  input  logic [RID_W-1:0] src_id,
  input  logic [RID_W-1:0] dst_id [N],
  output logic [N-1:0]     hit
);
  localparam logic [RID_W-1:0] NONE_ID = {RID_W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = (src_id != NONE_ID) && (dst_id[i] == src_id);
  end

  always_comb begin
    if (src_id == NONE_ID)
      AST_NONE_NEVER_HITS: assert (hit == '0); // R8
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] hit,
  output logic [N-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R2
    AST_GRANT_IN_HIT: assert ((grant & ~hit) == '0); // R3
    AST_ANY_HIT_GRANTS: assert ((hit == '0) || (grant != '0)); // R4
  end
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N      = 5
) (
  input  logic [N-1:0]      grant,
  input  logic [DATA_W-1:0] cand [N],
  input  logic [DATA_W-1:0] rf_val,
  output logic [DATA_W-1:0] sel_val
);
  always_comb begin
    sel_val = rf_val;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant[i]) sel_val = cand[i];
    end
  end

  always_comb begin
    if (grant == '0)
      AST_RF_WHEN_IDLE: assert (sel_val == rf_val); // R1
  end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned RID_W  = 4
) (
  input  logic [RID_W-1:0]  dec_src_a,
  input  logic [RID_W-1:0]  dec_src_b,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [DATA_W-1:0] dec_pc_next,
  input  logic              dec_use_pc,
  input  logic [RID_W-1:0]  ex_alu_dst,
  input  logic [DATA_W-1:0] ex_alu_val,
  input  logic [RID_W-1:0]  mem_load_dst,
  input  logic [DATA_W-1:0] mem_load_val,
  input  logic [RID_W-1:0]  mem_alu_dst,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [RID_W-1:0]  wb_load_dst,
  input  logic [DATA_W-1:0] wb_load_val,
  input  logic [RID_W-1:0]  wb_alu_dst,
  input  logic [DATA_W-1:0] wb_alu_val,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int unsigned N     = NUM_SRC;
  localparam int unsigned PORTS = 2;

  logic [RID_W-1:0]  dst_ids [N];
  logic [DATA_W-1:0] vals    [N];

  assign dst_ids[SRC_EX_ALU]   = ex_alu_dst;
  assign dst_ids[SRC_MEM_LOAD] = mem_load_dst;
  assign dst_ids[SRC_MEM_ALU]  = mem_alu_dst;
  assign dst_ids[SRC_WB_LOAD]  = wb_load_dst;
  assign dst_ids[SRC_WB_ALU]   = wb_alu_dst;
  assign vals[SRC_EX_ALU]      = ex_alu_val;
  assign vals[SRC_MEM_LOAD]    = mem_load_val;
  assign vals[SRC_MEM_ALU]     = mem_alu_val;
  assign vals[SRC_WB_LOAD]     = wb_load_val;
  assign vals[SRC_WB_ALU]      = wb_alu_val;

  logic [RID_W-1:0]  src_ids [PORTS];
  logic [DATA_W-1:0] rf_vals [PORTS];
  logic [DATA_W-1:0] bypass  [PORTS];

  assign src_ids[0] = dec_src_a;
  assign src_ids[1] = dec_src_b;
  assign rf_vals[0] = rf_data_a;
  assign rf_vals[1] = rf_data_b;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [N-1:0] hit;
    logic [N-1:0] grant;

    fwd_match #(.RID_W(RID_W), .N(N)) u_match (
      .src_id (src_ids[p]),
      .dst_id (dst_ids),
      .hit    (hit)
    );

    fwd_prio #(.N(N)) u_prio (
      .hit   (hit),
      .grant (grant)
    );

    fwd_opnd_mux #(.DATA_W(DATA_W), .N(N)) u_mux (
      .grant   (grant),
      .cand    (vals),
      .rf_val  (rf_vals[p]),
      .sel_val (bypass[p])
    );
  end

  // The PC path sits after the bypass mux, so it overrides every register match
  assign opnd_a = dec_use_pc ? dec_pc_next : bypass[0];
  assign opnd_b = bypass[1];

  always_comb begin
    if (!dec_use_pc)
      AST_A_FROM_BYPASS: assert (opnd_a == g_port[0].u_mux.sel_val); // R7
    AST_B_IGNORES_PC: assert (opnd_b == g_port[1].u_mux.sel_val); // R9
  end
endmodule

// File: tb/fwd_operand_sel_tb.sv
module fwd_operand_sel_tb;
  localparam int DW = 64;
  localparam int RW = 4;
  localparam logic [RW-1:0] NONE = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0] src_a, src_b, exd, mld, mad, wld, wad;
  logic [DW-1:0] rfa, rfb, pcn, exv, mlv, mav, wlv, wav, oa, ob;
  logic use_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fwd_operand_sel #(.DATA_W(DW), .RID_W(RW)) u_dut (
    .dec_src_a(src_a), .dec_src_b(src_b), .rf_data_a(rfa), .rf_data_b(rfb),
    .dec_pc_next(pcn), .dec_use_pc(use_pc),
    .ex_alu_dst(exd), .ex_alu_val(exv), .mem_load_dst(mld), .mem_load_val(mlv),
    .mem_alu_dst(mad), .mem_alu_val(mav), .wb_load_dst(wld), .wb_load_val(wlv),
    .wb_alu_dst(wad), .wb_alu_val(wav), .opnd_a(oa), .opnd_b(ob)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    src_a = 4'd1; src_b = 4'd2; rfa = 64'hA0; rfb = 64'hB0; pcn = 64'h1234; use_pc = 0;
    exd = NONE; mld = NONE; mad = NONE; wld = NONE; wad = NONE;
    exv = 64'h11; mlv = 64'h22; mav = 64'h33; wlv = 64'h44; wav = 64'h55;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    idle(); settle();
    check("R1 idle A", oa, 64'hA0);
    check("R1 idle B", ob, 64'hB0);
    exd = 4'd7; mad = 4'd8; settle();
    check("R1 other regs A", oa, 64'hA0);
  endtask

  task automatic t_priority();
    idle();
    exd = 4'd1; mld = 4'd1; mad = 4'd1; wld = 4'd1; wad = 4'd1; settle();
    check("R2 ex wins all", oa, 64'h11);
    exd = NONE; settle();
    check("R3 mem load wins", oa, 64'h22);
    mld = NONE; settle();
    check("R4 mem alu wins", oa, 64'h33);
    mad = NONE; settle();
    check("R5 wb load wins", oa, 64'h44);
    wld = NONE; settle();
    check("R6 wb alu wins", oa, 64'h55);
    wad = NONE; wld = 4'd1; exd = 4'd1; settle();
    check("R2 ex over wb load", oa, 64'h11);
  endtask

  task automatic t_pc();
    idle(); use_pc = 1; exd = 4'd1; src_b = 4'd1; settle();
    check("R7 pc overrides A", oa, 64'h1234);
    check("R7 B unaffected", ob, 64'h11);
    use_pc = 0; settle();
    check("R7 pc off", oa, 64'h11);
  endtask

  task automatic t_none();
    idle(); src_a = NONE; src_b = NONE; exd = NONE; wad = NONE; settle();
    check("R8 none A", oa, 64'hA0);
    check("R8 none B", ob, 64'hB0);
  endtask

  task automatic t_independent();
    idle(); mld = 4'd1; wad = 4'd2; settle();
    check("R9 A from mem load", oa, 64'h22);
    check("R9 B from wb alu", ob, 64'h55);
    src_b = 4'd1; settle();
    check("R9 same source both", ob, 64'h22);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_priority();
    t_pc();
    t_none();
    t_independent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule